// File: doc/BRIEF.md
# Nested Execution Lease Unit

This block sits next to a small processor's fetch stage and its data-memory write port. It hands untrusted code a sandbox bounded in both time and space: software pushes a lease that carries a cycle budget, the PC to return to, and a memory window given as a base address and a bit mask. Leases nest. The unit keeps them on an internal stack, and only the newest one is running at any time.

Each cycle the unit counts down the budget of the top lease. Stores that fall outside that lease's window have their write enable removed. When the budget runs out, the unit steers the fetch multiplexer to the saved PC for one cycle and pops the lease, so the enclosing lease picks up again with the budget it had left. When the last lease ends, the unit returns to its idle state, in which nothing is restricted. The remaining budget of the top lease can be read out. A scheduler can record it and later push it back as a new lease, which lets it save and restore a time slice.

Top module: `lease_unit`

## Requirements
- R1: After reset the depth reads 0, `pc_override` is low, `top_remaining` reads 0 and every store request is passed through.
- R2: A lease pushed with budget T shows `top_remaining` = T in the cycle after the push and loses one per cycle while it is on top. `pc_override` is high only in a cycle in which the top lease reads 0, and the lease is popped at the end of that cycle.
- R3: `pc_fetch` equals the top lease's saved PC while `pc_override` is high, and equals `pc_next` in every other cycle.
- R4: `depth` rises by one on each accepted push and falls by one on each expiry. When the bottom lease expires the unit becomes idle.
- R5: While idle (`depth` = 0), `st_we` equals `st_req`.
- R6: While a lease is active, `st_we` is high only if `st_req` is high and `((st_addr ^ base) & mask) == 0`. A 1 bit in the mask marks an address bit that must match the base.
- R7: A push while `depth` equals DEPTH raises `push_reject` in that cycle and changes neither the depth nor any stored lease.
- R8: A push in a cycle with `pc_override` high is rejected with `push_reject`, and the expiry goes ahead as normal.
- R9: Only the top lease counts down. The leases below it keep their budgets, and each one resumes from its kept value once it is exposed.
- R10: `top_remaining` reads 0 while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Request to push a new lease |
| push_time | input | TIME_W | Cycle budget of the new lease |
| push_pc | input | PC_W | PC restored when the new lease expires |
| push_base | input | ADDR_W | Base address of the new lease's window |
| push_mask | input | ADDR_W | Mask of address bits compared against the base |
| pc_next | input | PC_W | Next PC computed by the normal fetch path |
| st_req | input | 1 | Store request from the pipeline |
| st_addr | input | ADDR_W | Address of the store |
| pc_fetch | output | PC_W | PC to fetch next |
| pc_override | output | 1 | High in the expiry cycle |
| st_we | output | 1 | Gated write enable to data memory |
| push_reject | output | 1 | Push dropped, either because the stack is full or because of an expiry in the same cycle |
| depth | output | $clog2(DEPTH+1) | Number of leases held |
| top_remaining | output | TIME_W | Budget left on the top lease |

## Verification
The assertions check on every cycle that the stack pointer stays in range and moves by exactly one on each push and each pop, that stored budgets below the top never change, that stores pass untouched while idle, that the gated enable never exceeds the request, and that full or clashing pushes are refused. Whether a lease expires after the right number of cycles, whether a nested lease hands control back to its parent with the correct budget left, and whether the window matching gives the right result for a given base and mask can only be shown by the bench's scenarios. The bench compares every output against a behavioural stack model on every cycle.

// File: rtl/lease_pkg.sv
package lease_pkg;

  typedef enum logic [1:0] {
    PUSH_NONE  = 2'd0,
    PUSH_TAKE  = 2'd1,
    PUSH_FULL  = 2'd2,
    PUSH_CLASH = 2'd3
  } push_outcome_e;

endpackage

// File: rtl/lease_ctrl.sv
module lease_ctrl
  import lease_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_valid,
  input  logic            top_zero,
  output logic            push_take,
  output logic            pop,
  output logic            push_reject,
  output logic [SP_W-1:0] sp
);

  localparam logic [SP_W-1:0] SP_FULL = SP_W'(DEPTH);

  push_outcome_e outcome;
  logic          active;
  logic          full;
  logic [SP_W-1:0] sp_n;

  assign active = (sp != '0);
  assign full   = (sp == SP_FULL);
  assign pop    = active && top_zero;

  always_comb begin
    if (!push_valid)  outcome = PUSH_NONE;
    else if (pop)     outcome = PUSH_CLASH;
    else if (full)    outcome = PUSH_FULL;
    else              outcome = PUSH_TAKE;
  end

  assign push_take   = (outcome == PUSH_TAKE);
  assign push_reject = (outcome == PUSH_FULL) || (outcome == PUSH_CLASH);

  always_comb begin
    sp_n = sp;
    if (pop)            sp_n = sp - 1'b1;
    else if (push_take) sp_n = sp + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sp <= '0;
    else        sp <= sp_n;
  end

  assert_sp_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_FULL);

  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> sp == $past(sp) - 1'b1);

  assert_push_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_take |=> sp == $past(sp) + 1'b1);

  assert_full_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full) |-> (push_reject && !push_take));

  assert_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop) |-> (push_reject && !push_take));

endmodule

// File: rtl/lease_slot.sv
module lease_slot #(
  parameter int IDX    = 0,
  parameter int SP_W   = 3,
  parameter int TIME_W = 12,
  parameter int PC_W   = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SP_W-1:0]   sp,
  input  logic              push_take,
  input  logic              pop,
  input  logic [TIME_W-1:0] push_time,
  input  logic [PC_W-1:0]   push_pc,
  input  logic [ADDR_W-1:0] push_base,
  input  logic [ADDR_W-1:0] push_mask,
  output logic [TIME_W-1:0] cnt,
  output logic [PC_W-1:0]   pc,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] mask
);

  localparam logic [SP_W-1:0] MY_LOAD = SP_W'(IDX);
  localparam logic [SP_W-1:0] MY_TOP  = SP_W'(IDX + 1);

  function automatic logic [TIME_W-1:0] count_down(input logic [TIME_W-1:0] v);
    return v - 1'b1;
  endfunction

  logic is_top;
  logic load;

  assign is_top = (sp == MY_TOP);
  assign load   = push_take && (sp == MY_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pc   <= '0;
      base <= '0;
      mask <= '0;
    end else if (load) begin
      cnt  <= push_time;
      pc   <= push_pc;
      base <= push_base;
      mask <= push_mask;
    end else if (is_top && !pop) begin
      cnt  <= count_down(cnt);
    end
  end

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_top && !load) |=> $stable(cnt));

endmodule

// File: rtl/lease_region.sv
module lease_region #(
  parameter int ADDR_W = 16
) (
  input  logic              active,
  input  logic              st_req,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic              st_we
);

  function automatic logic window_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] b,
                                      input logic [ADDR_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  logic hit;
  assign hit   = window_hit(st_addr, base, mask);
  assign st_we = st_req && (!active || hit);

endmodule

// File: rtl/lease_unit.sv
module lease_unit #(
  parameter int DEPTH  = 4,
  parameter int TIME_W = 12,
  parameter int PC_W   = 16,
  parameter int ADDR_W = 16,
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [TIME_W-1:0] push_time,
  input  logic [PC_W-1:0]   push_pc,
  input  logic [ADDR_W-1:0] push_base,
  input  logic [ADDR_W-1:0] push_mask,
  input  logic [PC_W-1:0]   pc_next,
  input  logic              st_req,
  input  logic [ADDR_W-1:0] st_addr,
  output logic [PC_W-1:0]   pc_fetch,
  output logic              pc_override,
  output logic              st_we,
  output logic              push_reject,
  output logic [SP_W-1:0]   depth,
  output logic [TIME_W-1:0] top_remaining
);

  logic [TIME_W-1:0] cnt_a  [DEPTH];
  logic [PC_W-1:0]   pc_a   [DEPTH];
  logic [ADDR_W-1:0] base_a [DEPTH];
  logic [ADDR_W-1:0] mask_a [DEPTH];

  logic [SP_W-1:0]   sp;
  logic              push_take;
  logic              expire_evt;
  logic              lease_active;
  logic [TIME_W-1:0] top_cnt;
  logic [PC_W-1:0]   top_pc;
  logic [ADDR_W-1:0] top_base;
  logic [ADDR_W-1:0] top_mask;
  logic              top_zero;

  lease_ctrl #(.DEPTH(DEPTH), .SP_W(SP_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .top_zero   (top_zero),
    .push_take  (push_take),
    .pop        (expire_evt),
    .push_reject(push_reject),
    .sp         (sp)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    lease_slot #(
      .IDX(g), .SP_W(SP_W), .TIME_W(TIME_W), .PC_W(PC_W), .ADDR_W(ADDR_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .sp       (sp),
      .push_take(push_take),
      .pop      (expire_evt),
      .push_time(push_time),
      .push_pc  (push_pc),
      .push_base(push_base),
      .push_mask(push_mask),
      .cnt      (cnt_a[g]),
      .pc       (pc_a[g]),
      .base     (base_a[g]),
      .mask     (mask_a[g])
    );
  end

  always_comb begin
    top_cnt  = '0;
    top_pc   = '0;
    top_base = '0;
    top_mask = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp == SP_W'(i + 1)) begin
        top_cnt  = cnt_a[i];
        top_pc   = pc_a[i];
        top_base = base_a[i];
        top_mask = mask_a[i];
      end
    end
  end

  assign lease_active  = (sp != '0);
  assign top_zero      = (top_cnt == '0);
  assign pc_override   = expire_evt;
  assign pc_fetch      = expire_evt ? top_pc : pc_next;
  assign depth         = sp;
  assign top_remaining = top_cnt;

  lease_region #(.ADDR_W(ADDR_W)) u_region (
    .active (lease_active),
    .st_req (st_req),
    .st_addr(st_addr),
    .base   (top_base),
    .mask   (top_mask),
    .st_we  (st_we)
  );

  assert_idle_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lease_active |-> (st_we == st_req));

  assert_we_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> st_req);

  assert_override_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_override |-> (lease_active && top_remaining == '0));

  assert_idle_remaining_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lease_active |-> (top_remaining == '0 && !pc_override));

endmodule

// File: tb/tb_lease_unit.sv
module tb_lease_unit;

  localparam int DEPTH  = 4;
  localparam int TIME_W = 12;
  localparam int PC_W   = 16;
  localparam int ADDR_W = 16;
  localparam int SP_W   = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              push_valid = 1'b0;
  logic [TIME_W-1:0] push_time = '0;
  logic [PC_W-1:0]   push_pc = '0;
  logic [ADDR_W-1:0] push_base = '0;
  logic [ADDR_W-1:0] push_mask = '0;
  logic [PC_W-1:0]   pc_next = '0;
  logic              st_req = 1'b0;
  logic [ADDR_W-1:0] st_addr = '0;
  logic [PC_W-1:0]   pc_fetch;
  logic              pc_override;
  logic              st_we;
  logic              push_reject;
  logic [SP_W-1:0]   depth;
  logic [TIME_W-1:0] top_remaining;

  always #10 clk = ~clk;

  lease_unit #(.DEPTH(DEPTH), .TIME_W(TIME_W), .PC_W(PC_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_time(push_time),
    .push_pc(push_pc), .push_base(push_base), .push_mask(push_mask),
    .pc_next(pc_next), .st_req(st_req), .st_addr(st_addr),
    .pc_fetch(pc_fetch), .pc_override(pc_override), .st_we(st_we),
    .push_reject(push_reject), .depth(depth), .top_remaining(top_remaining)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  int m_sp = 0;
  int m_cnt  [DEPTH];
  int m_pc   [DEPTH];
  int m_base [DEPTH];
  int m_mask [DEPTH];

  task automatic chk(input string what, input string req, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cycle();
    bit exp_ovr, exp_rej, exp_we;
    int top, exp_pc, exp_rem;
    #1;
    top     = m_sp - 1;
    exp_ovr = (m_sp > 0) && (m_cnt[top] == 0);
    exp_rej = push_valid && ((m_sp == DEPTH) || exp_ovr);
    exp_pc  = exp_ovr ? m_pc[top] : int'(pc_next);
    exp_rem = (m_sp > 0) ? m_cnt[top] : 0;
    if (m_sp == 0) exp_we = st_req;
    else exp_we = st_req && (((int'(st_addr) ^ m_base[top]) & m_mask[top]) == 0);
    vectors++;
    chk("pc_override", "R2", int'(pc_override), int'(exp_ovr));
    chk("pc_fetch", "R3", int'(pc_fetch), exp_pc);
    chk("depth", "R4", int'(depth), m_sp);
    chk("st_we", m_sp == 0 ? "R5" : "R6", int'(st_we), int'(exp_we));
    chk("push_reject", exp_ovr ? "R8" : "R7", int'(push_reject), int'(exp_rej));
    chk("top_remaining", m_sp == 0 ? "R10" : "R9", int'(top_remaining), exp_rem);
    @(posedge clk);
    if (exp_ovr) m_sp--;
    else begin
      if (m_sp > 0) m_cnt[top]--;
      if (push_valid && m_sp < DEPTH) begin
        m_cnt[m_sp]  = int'(push_time);
        m_pc[m_sp]   = int'(push_pc);
        m_base[m_sp] = int'(push_base);
        m_mask[m_sp] = int'(push_mask);
        m_sp++;
      end
    end
    @(negedge clk);
  endtask

  task automatic step(input bit pv, input int t, input int pc, input int b, input int m,
                      input bit sr, input int a);
    push_valid = pv;
    push_time  = TIME_W'(t);
    push_pc    = PC_W'(pc);
    push_base  = ADDR_W'(b);
    push_mask  = ADDR_W'(m);
    st_req     = sr;
    st_addr    = ADDR_W'(a);
    pc_next    = PC_W'($urandom);
    cycle();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, $urandom_range(0, 1), $urandom);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, idle stores pass (R5), remaining zero (R10)
    #1;
    vectors++;
    chk("depth after reset", "R1", int'(depth), 0);
    chk("override after reset", "R1", int'(pc_override), 0);
    chk("remaining after reset", "R1", int'(top_remaining), 0);
    @(negedge clk);
    step(0, 0, 0, 0, 0, 1, 16'h1234);

    // R2/R6: single lease, stores inside and outside the window
    step(1, 3, 16'h0100, 16'h4000, 16'hF000, 0, 0);
    step(0, 0, 0, 0, 0, 1, 16'h4123);
    step(0, 0, 0, 0, 0, 1, 16'h5123);
    step(0, 0, 0, 0, 0, 1, 16'h4FFF);
    idle(4);

    // R9: nested leases, outer resumes with kept budget
    step(1, 20, 16'h0200, 16'h8000, 16'hC000, 0, 0);
    step(1, 4, 16'h0300, 16'h8800, 16'hFF00, 1, 16'h8810);
    idle(30);

    // R7: fill the stack then push once more
    for (int k = 0; k < DEPTH; k++) step(1, 40 + k, 16'h0400 + k, 0, 0, 0, 0);
    step(1, 7, 16'h0500, 0, 0, 1, 16'hABCD);
    idle(200);

    // R8: push in the expiry cycle
    step(1, 2, 16'h0600, 16'h0000, 16'h0000, 0, 0);
    idle(2);
    step(1, 5, 16'h0700, 0, 0, 0, 0);
    idle(10);

    // R2: zero budget expires right after the push
    step(1, 0, 16'h0800, 0, 16'hFFFF, 1, 0);
    idle(3);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 7) == 0)
        step(1, $urandom_range(0, 15), $urandom, $urandom, $urandom, $urandom_range(0, 1), $urandom);
      else
        step(0, 0, 0, 0, 0, $urandom_range(0, 1), $urandom);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule